// File: doc/BRIEF.md
# Ternary Masked Match-Array Memory

This block is a ternary content memory with a configurable number of entries. Each entry holds three things: a stored word, a mask word of the same width, and a valid flag. A mask bit of 1 makes that bit position a wildcard. A write port loads all three parts of one addressed entry in a single clock.

A search port compares one key against every entry at once. One clock later it returns the raw hit vector, which has one bit per entry. The block does not encode the vector and does not pick a winner. Several such memories, each searched on a different header field, can therefore be combined bit for bit by the logic around them. That logic also turns the combined vector into a rule index.

The default key width is 128 bits, so a whole IPv6 address fits in one memory.

Top module: `tern_match_mem`

## Requirements
- R1: A bit position whose stored mask bit is 1 is a wildcard. It never stops the entry from matching, whatever the key bit and the stored bit are.
- R2: A bit position whose mask bit is 0 passes only when the key bit equals the stored bit. An entry hits only when every bit position across the full key width passes and the entry is valid.
- R3: A search accepted while `lookup_en` is 1 produces `match_vec` and a one-cycle `match_stb` pulse on the next clock edge. The latency is fixed at one cycle whatever the data.
- R4: All entries are compared in the same cycle. Bit e of `match_vec` belongs to entry e. Any number of bits may be 1 together, and no priority is applied.
- R5: After reset every entry is invalid, `match_vec` is all zero and `match_stb` is 0.
- R6: A write with `wr_en` at 1 loads `wr_data`, `wr_mask` and `wr_valid` into entry `wr_addr`. No other entry changes.
- R7: An invalid entry never sets its hit bit, even when its mask is all ones.
- R8: When a write and a search fall in the same cycle, that search sees the entry as it was before the write. Only later searches see the new contents.
- R9: In a cycle with `lookup_en` at 0, `match_stb` goes to 0 on the next edge and `match_vec` keeps its last value.
- R10: A write whose `wr_addr` is at or above the entry count changes no entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for one entry |
| wr_addr | input | IDX_W | Index of the entry to write |
| wr_data | input | KEY_W | Stored word to load |
| wr_mask | input | KEY_W | Mask to load; 1 marks a wildcard bit |
| wr_valid | input | 1 | Valid flag to load |
| lookup_en | input | 1 | Search request for the key on `lookup_key` |
| lookup_key | input | KEY_W | Search key |
| match_vec | output | ENTRIES | Registered hit vector, bit e for entry e |
| match_stb | output | 1 | Marks the cycle in which `match_vec` holds a new result |

## Verification
Two functions can fall in the same cycle: an update of an entry and a search that reads that same entry. The bench drives both at once. In some cases the write makes an entry valid and the key matches only the new contents. In other cases the write makes an entry invalid and the key matches only the old contents. The result of that cycle must follow the old contents (R8). A behavioural model commits its own write only after computing the expected vector, and the search issued on the following cycle must then show the new contents.

// File: rtl/tmm_pkg.sv
package tmm_pkg;

    localparam int unsigned TMM_DEF_KEY_W   = 128;
    localparam int unsigned TMM_DEF_ENTRIES = 16;

    // width of an index able to name n entries (never below one bit)
    function automatic int unsigned tmm_idx_w(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/tmm_entry.sv
module tmm_entry #(
    parameter int unsigned KEY_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [KEY_W-1:0] wdata,
    input  logic [KEY_W-1:0] wmask,
    input  logic             wvalid,
    output logic [KEY_W-1:0] data_o,
    output logic [KEY_W-1:0] mask_o,
    output logic             valid_o
);

    typedef struct packed {
        logic             vld;
        logic [KEY_W-1:0] dat;
        logic [KEY_W-1:0] msk;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (we) begin
            slot_d.vld = wvalid;
            slot_d.dat = wdata;
            slot_d.msk = wmask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign data_o  = slot_q.dat;
    assign mask_o  = slot_q.msk;
    assign valid_o = slot_q.vld;

    // R5: entry leaves reset invalid
    assert_clear_after_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !valid_o);

    // R6: without a write strobe the entry keeps its contents
    assert_hold_unwritten_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> ($stable(valid_o) && $stable(data_o) && $stable(mask_o)));

endmodule

// File: rtl/tmm_cmp.sv
module tmm_cmp #(
    parameter int unsigned KEY_W = 128
) (
    input  logic [KEY_W-1:0] key,
    input  logic [KEY_W-1:0] data,
    input  logic [KEY_W-1:0] mask,
    input  logic             valid,
    output logic             hit
);

    logic [KEY_W-1:0] bit_ok;

    // per-bit ternary rule: wildcard or equal
    always_comb begin
        bit_ok = mask | ~(key ^ data);
        hit    = valid & (&bit_ok);
    end

endmodule

// File: rtl/tern_match_mem.sv
module tern_match_mem
    import tmm_pkg::*;
#(
    parameter int unsigned KEY_W   = TMM_DEF_KEY_W,
    parameter int unsigned ENTRIES = TMM_DEF_ENTRIES,
    localparam int unsigned IDX_W  = tmm_idx_w(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_addr,
    input  logic [KEY_W-1:0]   wr_data,
    input  logic [KEY_W-1:0]   wr_mask,
    input  logic               wr_valid,
    input  logic               lookup_en,
    input  logic [KEY_W-1:0]   lookup_key,
    output logic [ENTRIES-1:0] match_vec,
    output logic               match_stb
);

    typedef struct packed {
        logic [ENTRIES-1:0] vec;
        logic               stb;
    } res_t;

    logic [ENTRIES-1:0] hit_w;
    logic [ENTRIES-1:0] valid_w;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
        logic             we_e;
        logic [KEY_W-1:0] dat_e;
        logic [KEY_W-1:0] msk_e;

        assign we_e = wr_en && (wr_addr == IDX_W'(e));

        tmm_entry #(.KEY_W(KEY_W)) i_entry (
            .clk     (clk),
            .rst_n   (rst_n),
            .we      (we_e),
            .wdata   (wr_data),
            .wmask   (wr_mask),
            .wvalid  (wr_valid),
            .data_o  (dat_e),
            .mask_o  (msk_e),
            .valid_o (valid_w[e])
        );

        tmm_cmp #(.KEY_W(KEY_W)) i_cmp (
            .key   (lookup_key),
            .data  (dat_e),
            .mask  (msk_e),
            .valid (valid_w[e]),
            .hit   (hit_w[e])
        );
    end

    res_t res_d, res_q;

    always_comb begin
        res_d     = res_q;
        res_d.stb = lookup_en;
        if (lookup_en) begin
            res_d.vec = hit_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign match_vec = res_q.vec;
    assign match_stb = res_q.stb;

    // R3: a search yields a strobe on the next edge
    assert_strobe_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lookup_en |=> match_stb);

    // R9: idle cycle drops strobe and holds the vector
    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !lookup_en |=> (!match_stb && $stable(match_vec)));

    // R7: no hit reported for an entry that was invalid at search time
    assert_invalid_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lookup_en |=> ((match_vec & ~$past(valid_w)) == '0));

endmodule

// File: tb/test_tern_match_mem.sv
module test_tern_match_mem;

    localparam int KW = 16;
    localparam int NE = 6;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [KW-1:0] wr_data = '0;
    logic [KW-1:0] wr_mask = '0;
    logic          wr_valid = 1'b0;
    logic          lookup_en = 1'b0;
    logic [KW-1:0] lookup_key = '0;
    logic [NE-1:0] match_vec;
    logic          match_stb;

    tern_match_mem #(.KEY_W(KW), .ENTRIES(NE)) i_tern_match_mem (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_mask(wr_mask), .wr_valid(wr_valid),
        .lookup_en(lookup_en), .lookup_key(lookup_key),
        .match_vec(match_vec), .match_stb(match_stb)
    );

    always #4 clk = ~clk;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    // behavioural model
    logic [KW-1:0] m_dat [NE];
    logic [KW-1:0] m_msk [NE];
    bit            m_vld [NE];
    logic [NE-1:0] exp_vec = '0;
    bit            exp_stb = 1'b0;

    function automatic logic [NE-1:0] model_search(input logic [KW-1:0] k);
        logic [NE-1:0] r = '0;
        for (int e = 0; e < NE; e++) begin
            bit ok = m_vld[e];
            for (int b = 0; b < KW; b++) begin
                if (!m_msk[e][b] && (k[b] !== m_dat[e][b])) ok = 1'b0;
            end
            r[e] = ok;
        end
        return r;
    endfunction

    task automatic check(input string req);
        tests++;
        if (match_vec !== exp_vec || match_stb !== exp_stb) begin
            fails++;
            $display("FAIL %s: vec=%b stb=%b expected vec=%b stb=%b",
                     req, match_vec, match_stb, exp_vec, exp_stb);
        end
    endtask

    // inputs are already set; one edge, then model update, then compare
    task automatic step(input string req);
        @(posedge clk);
        if (lookup_en) begin
            exp_vec = model_search(lookup_key);
            exp_stb = 1'b1;
        end else begin
            exp_stb = 1'b0;
        end
        if (wr_en && wr_addr < NE) begin
            m_dat[wr_addr] = wr_data;
            m_msk[wr_addr] = wr_mask;
            m_vld[wr_addr] = wr_valid;
        end
        @(negedge clk);
        check(req);
        wr_en     = 1'b0;
        lookup_en = 1'b0;
    endtask

    task automatic put(input int a, input logic [KW-1:0] d, input logic [KW-1:0] m,
                       input bit v, input string req);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d; wr_mask = m; wr_valid = v;
        step(req);
    endtask

    task automatic find(input logic [KW-1:0] k, input string req);
        lookup_en = 1'b1; lookup_key = k;
        step(req);
    endtask

    initial begin
        for (int e = 0; e < NE; e++) begin
            m_dat[e] = '0; m_msk[e] = '0; m_vld[e] = 1'b0;
        end
        repeat (3) @(negedge clk);
        // R5: reset values
        tests++;
        if (match_vec !== '0 || match_stb !== 1'b0) begin
            fails++;
            $display("FAIL R5: vec=%b stb=%b expected vec=0 stb=0", match_vec, match_stb);
        end
        rst_n = 1'b1;
        @(negedge clk);
        // R5: entries invalid, so an all-wildcard search hits nothing
        find(16'h0000, "R5");
        // R7: invalid entry with full wildcard mask stays silent
        put(0, 16'h0000, 16'hFFFF, 1'b0, "R7");
        find(16'hBEEF, "R7");
        // R6: loading entries one by one
        put(0, 16'h1234, 16'h0000, 1'b1, "R6");
        find(16'h1234, "R6");
        put(1, 16'h1200, 16'h00FF, 1'b1, "R6");
        put(2, 16'h0000, 16'hFFFF, 1'b1, "R6");
        put(3, 16'hA5A5, 16'h0F0F, 1'b1, "R6");
        put(4, 16'h1234, 16'hFFFF, 1'b0, "R7");
        put(5, 16'h0000, 16'h8001, 1'b1, "R6");
        // R4: several entries hit together
        find(16'h1234, "R4");
        find(16'h12FF, "R4");
        // R2: single-bit difference against the exact entry
        find(16'h1235, "R2");
        find(16'h9234, "R2");
        // R9: idle cycles hold the last vector and drop the strobe
        step("R9");
        step("R9");
        // R1 and R2: sweep every key against the loaded table
        for (int k = 0; k < 65536; k++) begin
            lookup_en = 1'b1; lookup_key = KW'(k);
            step((k % 2 == 0) ? "R1" : "R2");
        end
        // R3: back-to-back searches each produce a result
        find(16'hA0A0, "R3");
        find(16'h5A5A, "R3");
        // R8: write that validates entry 4 together with a matching search
        wr_en = 1'b1; wr_addr = 3'd4; wr_data = 16'h7777; wr_mask = 16'h0000; wr_valid = 1'b1;
        lookup_en = 1'b1; lookup_key = 16'h7777;
        step("R8");
        find(16'h7777, "R8");
        // R8: write that invalidates entry 0 while it is searched
        wr_en = 1'b1; wr_addr = 3'd0; wr_data = 16'h1234; wr_mask = 16'h0000; wr_valid = 1'b0;
        lookup_en = 1'b1; lookup_key = 16'h1234;
        step("R8");
        find(16'h1234, "R8");
        // R10: writes beyond the last entry have no effect
        put(6, 16'hCCCC, 16'h0000, 1'b1, "R10");
        put(7, 16'hDDDD, 16'hFFFF, 1'b1, "R10");
        find(16'hCCCC, "R10");
        find(16'hDDDD, "R10");
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule